// File: doc/BRIEF.md
# Dual-Direction Equalizer Control Wrapper

This block sits in front of a shared FIR arithmetic engine and holds two independent filter contexts, one for the transmit path and one for the receive path. Each context has an enable flag, a tap count (the order), a coefficient table and a history of earlier input samples. A host configures each context through a small command port. Coefficients are streamed in after a load command that carries their size in bytes.

When a frame of samples arrives for a direction, the block does one of two things. If that direction is disabled or its order is zero, it returns the frame unchanged. Otherwise it builds one contiguous window from the stored history and the new frame, starts the engine through a start/done handshake, and hands back the engine's result. It then refreshes that direction's history with the newest inputs.

An odd requested order is padded up to the next even order with a zero tap, so the engine only ever sees even orders. Transmit and receive frames share the single engine, and a transmit request wins when both directions ask in the same cycle.

Top module: `eq_dir_ctrl`

## Requirements
- R1: The command code is `cmd_op` (0 tx enable, 1 rx enable, 2 tx order, 3 rx order, 4 tx coefficient load, 5 rx coefficient load; bit 0 selects the direction). An enable command takes argument 0 to disable and 1 to enable. Any other argument, and the codes 6 and 7, raise `cmd_err` for one cycle in the cycle after acceptance.
- R2: An order command accepts an argument from 0 to MAXN. A larger value raises `cmd_err` and leaves that direction's order, coefficients and history unchanged.
- R3: An odd requested order n is stored as n+1, which is what `eng_ord` shows. A later coefficient load for that direction writes zero into tap index n.
- R4: A coefficient load is accepted only when its byte count equals twice the requested order of that direction. The block then takes that many 16-bit words on `cf_valid`/`cf_data`, tap 0 first. A mismatch raises `cmd_err` and writes no tap.
- R5: A frame for a direction that is disabled or has order 0 is returned unchanged on `fr_out`, with its done pulse in the cycle after the request is taken and no `eng_start`.
- R6: For a filtered frame, `eng_win` holds WL=MAXN-1+FRAME samples, sample j at bits j*DW. Samples MAXN-1 to WL-1 are the new frame in order. The N-1 samples just below index MAXN-1 are the stored history, newest at index MAXN-2. All older slots are zero. `eng_coef` holds tap i at bits i*CW, and taps at or above the order are zero.
- R7: After a filtered frame, the history of that direction holds its most recent inputs. A bypassed frame leaves the history untouched.
- R8: Every accepted order command clears that direction's history to zero.
- R9: When transmit and receive frames are both requested in the same idle cycle, the transmit frame is served first, and the receive frame follows once the transmit frame is done.
- R10: Commands and frames for one direction do not alter the enable flag, order, coefficients or history of the other.
- R11: `eng_start` is a one-cycle pulse. The window and coefficients stay stable until `eng_done`. `fr_out` then carries the `eng_out` captured at `eng_done`, with the done pulse one cycle later.
- R12: `cmd_ready` is high only when the block is idle and no frame request is pending, so configuration cannot change during a frame or a coefficient stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Command code |
| cmd_arg | input | AW | Enable value, order or byte count |
| cmd_err | output | 1 | One-cycle pulse for a rejected command |
| cf_valid | input | 1 | Coefficient word present |
| cf_data | input | CW | Coefficient word |
| tx_req | input | 1 | Transmit frame request, held until tx_done |
| tx_in | input | FRAME*DW | Transmit frame, sample i at bits i*DW |
| rx_req | input | 1 | Receive frame request, held until rx_done |
| rx_in | input | FRAME*DW | Receive frame |
| tx_done | output | 1 | Transmit frame result valid |
| rx_done | output | 1 | Receive frame result valid |
| fr_out | output | FRAME*DW | Result frame |
| eng_start | output | 1 | Engine launch pulse |
| eng_ord | output | OW | Even order for the engine |
| eng_win | output | WL*DW | History plus frame window |
| eng_coef | output | MAXN*CW | Masked coefficient table |
| eng_done | input | 1 | Engine result valid |
| eng_out | input | FRAME*DW | Engine result frame |

## Verification
A wrong enable flag or order shows at once on the next frame. The frame either comes back raw with no engine launch, or launches with the wrong `eng_ord`. Stale or misaligned history shows on `eng_win` at the start of the next filtered frame of that direction, one frame after the update that went wrong. A missed pad tap or a partial coefficient stream shows in `eng_coef` at that same launch. A lost priority or a context leak between directions shows up as the wrong done pulse, or as one direction's window carrying the other's samples.

// File: rtl/eq_dir_ctrl.sv
module eq_dir_ctrl #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int AW    = 16,
  parameter int MAXN  = 8,
  parameter int FRAME = 4,
  localparam int OW   = $clog2(MAXN + 1),
  localparam int CIW  = $clog2(MAXN),
  localparam int HL   = MAXN - 1,
  localparam int WL   = HL + FRAME
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [2:0]          cmd_op,
  input  logic [AW-1:0]       cmd_arg,
  output logic                cmd_err,
  input  logic                cf_valid,
  input  logic [CW-1:0]       cf_data,
  input  logic                tx_req,
  input  logic [FRAME*DW-1:0] tx_in,
  input  logic                rx_req,
  input  logic [FRAME*DW-1:0] rx_in,
  output logic                tx_done,
  output logic                rx_done,
  output logic [FRAME*DW-1:0] fr_out,
  output logic                eng_start,
  output logic [OW-1:0]       eng_ord,
  output logic [WL*DW-1:0]    eng_win,
  output logic [MAXN*CW-1:0]  eng_coef,
  input  logic                eng_done,
  input  logic [FRAME*DW-1:0] eng_out
);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_FIN} st_t;

  st_t                st;
  logic               en_q  [2];
  logic [OW-1:0]      ord_q [2];
  logic [OW-1:0]      rq_q  [2];
  logic [CW-1:0]      cf_q  [2][MAXN];
  logic [DW-1:0]      hs_q  [2][HL];
  logic [DW-1:0]      frm_q [FRAME];
  logic               dir_q, ld_dir, start_q, err_q;
  logic [CIW-1:0]     ld_idx;
  logic [OW-1:0]      ld_end;
  logic [FRAME*DW-1:0] out_q;

  wire idle   = (st == S_IDLE);
  wire launch = idle && (tx_req || rx_req);
  wire ldir   = !tx_req;
  wire [FRAME*DW-1:0] lin = tx_req ? tx_in : rx_in;
  wire lfilt  = en_q[ldir] && (ord_q[ldir] != '0);
  wire cd     = cmd_op[0];

  assign cmd_ready = idle && !tx_req && !rx_req;
  wire acc = cmd_valid && cmd_ready;

  logic bad;
  always_comb begin
    case (cmd_op[2:1])
      2'd0:    bad = cmd_arg > AW'(1);
      2'd1:    bad = cmd_arg > AW'(MAXN);
      2'd2:    bad = cmd_arg != AW'({rq_q[cd], 1'b0});
      default: bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      dir_q <= 1'b0;
      ld_dir <= 1'b0;
      ld_idx <= '0;
      ld_end <= '0;
      start_q <= 1'b0;
      err_q <= 1'b0;
      out_q <= '0;
      for (int f = 0; f < FRAME; f++) frm_q[f] <= '0;
      for (int d = 0; d < 2; d++) begin
        en_q[d] <= 1'b0;
        ord_q[d] <= '0;
        rq_q[d] <= '0;
        for (int i = 0; i < MAXN; i++) cf_q[d][i] <= '0;
        for (int a = 0; a < HL; a++) hs_q[d][a] <= '0;
      end
    end else begin
      start_q <= 1'b0;
      err_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (launch) begin
            dir_q <= ldir;
            for (int f = 0; f < FRAME; f++) frm_q[f] <= lin[f*DW +: DW];
            if (lfilt) begin
              st <= S_RUN;
              start_q <= 1'b1;
            end else begin
              out_q <= lin;
              st <= S_FIN;
            end
          end else if (acc) begin
            if (bad) begin
              err_q <= 1'b1;
            end else begin
              case (cmd_op[2:1])
                2'd0: en_q[cd] <= cmd_arg[0];
                2'd1: begin
                  ord_q[cd] <= OW'(cmd_arg) + OW'(cmd_arg[0]);
                  rq_q[cd] <= OW'(cmd_arg);
                  for (int a = 0; a < HL; a++) hs_q[cd][a] <= '0;
                end
                default: begin
                  if (rq_q[cd][0]) cf_q[cd][CIW'(rq_q[cd])] <= '0;
                  ld_dir <= cd;
                  ld_idx <= '0;
                  ld_end <= rq_q[cd];
                  if (rq_q[cd] != '0) st <= S_LOAD;
                end
              endcase
            end
          end
        end
        S_LOAD: begin
          if (cf_valid) begin
            cf_q[ld_dir][ld_idx] <= cf_data;
            ld_idx <= ld_idx + CIW'(1);
            if ((OW'(ld_idx) + OW'(1)) == ld_end) st <= S_IDLE;
          end
        end
        S_RUN: begin
          if (eng_done) begin
            out_q <= eng_out;
            for (int a = 0; a < HL; a++) begin
              if (a < FRAME) hs_q[dir_q][a] <= frm_q[(a < FRAME) ? FRAME-1-a : 0];
              else           hs_q[dir_q][a] <= hs_q[dir_q][(a >= FRAME) ? a-FRAME : 0];
            end
            st <= S_FIN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int j = 0; j < WL; j++) begin
      if (j >= HL)
        eng_win[j*DW +: DW] = frm_q[(j >= HL) ? j-HL : 0];
      else if ((HL-1-j) < int'(ord_q[dir_q]) - 1)
        eng_win[j*DW +: DW] = hs_q[dir_q][(j < HL) ? HL-1-j : 0];
      else
        eng_win[j*DW +: DW] = '0;
    end
    for (int i = 0; i < MAXN; i++)
      eng_coef[i*CW +: CW] = (i < int'(ord_q[dir_q])) ? cf_q[dir_q][i] : '0;
  end

  assign eng_ord   = ord_q[dir_q];
  assign eng_start = start_q;
  assign cmd_err   = err_q;
  assign fr_out    = out_q;
  assign tx_done   = (st == S_FIN) && !dir_q;
  assign rx_done   = (st == S_FIN) && dir_q;

endmodule

// File: rtl/eq_dir_ctrl_chk.sv
module eq_dir_ctrl_chk #(
  parameter int OW = 4,
  parameter int WW = 176
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_err,
  input logic          tx_req,
  input logic          tx_done,
  input logic          rx_done,
  input logic          eng_start,
  input logic          eng_done,
  input logic [OW-1:0] eng_ord,
  input logic [WW-1:0] eng_win,
  input logic [1:0]    st_i,
  input logic          dir_i
);

  a_r11_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  a_r3_even_order: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (eng_ord != '0 && !eng_ord[0]));

  a_r9_tx_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st_i == 2'd0 && tx_req) |=> (!dir_i && st_i != 2'd0));

  a_r10_one_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_done && rx_done));

  a_r1_err_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cmd_valid && cmd_ready));

  a_r11_window_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st_i == 2'd2 && !eng_done) |=> $stable(eng_win));

  a_r12_no_cmd_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!tx_done && !rx_done));

endmodule

bind eq_dir_ctrl eq_dir_ctrl_chk #(.OW(OW), .WW(WL*DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_err(cmd_err), .tx_req(tx_req), .tx_done(tx_done), .rx_done(rx_done),
  .eng_start(eng_start), .eng_done(eng_done), .eng_ord(eng_ord),
  .eng_win(eng_win), .st_i(st), .dir_i(dir_q)
);

// File: tb/sim_eq_dir_ctrl.sv
module sim_eq_dir_ctrl;
  localparam int DW = 16, CW = 16, AW = 16, MAXN = 8, FRAME = 4;
  localparam int OW = $clog2(MAXN + 1), HL = MAXN - 1, WL = HL + FRAME;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cf_valid = 0, tx_req = 0, rx_req = 0, eng_done = 0;
  logic [2:0] cmd_op = 0;
  logic [AW-1:0] cmd_arg = 0;
  logic [CW-1:0] cf_data = 0;
  logic [FRAME*DW-1:0] tx_in = 0, rx_in = 0, eng_out = 0, fr_out;
  logic cmd_ready, cmd_err, tx_done, rx_done, eng_start;
  logic [OW-1:0] eng_ord;
  logic [WL*DW-1:0] eng_win;
  logic [MAXN*CW-1:0] eng_coef;

  always #2.5 clk = ~clk;

  eq_dir_ctrl #(.DW(DW), .CW(CW), .AW(AW), .MAXN(MAXN), .FRAME(FRAME)) u0 (.*);

  int n_run = 0, n_fail = 0, n_starts = 0;
  bit finished = 0;
  logic [WL*DW-1:0] cap_win;
  logic [MAXN*CW-1:0] cap_coef;
  logic [OW-1:0] cap_ord;

  logic m_en [2];
  int m_ord [2];
  logic [CW-1:0] m_cf [2][MAXN];
  logic [DW-1:0] m_hs [2][HL];

  task automatic chk(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    if (eng_start) begin
      n_starts++;
      cap_win = eng_win; cap_coef = eng_coef; cap_ord = eng_ord;
      repeat (3) @(negedge clk);
      for (int i = 0; i < FRAME; i++) eng_out[i*DW +: DW] = cap_win[(HL+i)*DW +: DW] + 16'h1000;
      eng_done = 1;
      @(negedge clk);
      eng_done = 0;
    end
  end

  function automatic logic [FRAME*DW-1:0] mk(input logic [15:0] base);
    logic [FRAME*DW-1:0] v;
    for (int i = 0; i < FRAME; i++) v[i*DW +: DW] = base + 16'(i);
    return v;
  endfunction

  function automatic logic [WL*DW-1:0] exp_win(input int d, input logic [FRAME*DW-1:0] fin);
    logic [WL*DW-1:0] w;
    for (int j = 0; j < WL; j++) begin
      if (j >= HL) w[j*DW +: DW] = fin[(j-HL)*DW +: DW];
      else if (HL-1-j < m_ord[d]-1) w[j*DW +: DW] = m_hs[d][HL-1-j];
      else w[j*DW +: DW] = '0;
    end
    return w;
  endfunction

  function automatic logic [MAXN*CW-1:0] exp_coef(input int d);
    logic [MAXN*CW-1:0] c;
    for (int i = 0; i < MAXN; i++) c[i*CW +: CW] = (i < m_ord[d]) ? m_cf[d][i] : '0;
    return c;
  endfunction

  task automatic upd_hist(input int d, input logic [FRAME*DW-1:0] fin);
    logic [DW-1:0] old [HL];
    for (int a = 0; a < HL; a++) old[a] = m_hs[d][a];
    for (int a = 0; a < HL; a++)
      m_hs[d][a] = (a < FRAME) ? fin[(FRAME-1-a)*DW +: DW] : old[a-FRAME];
  endtask

  task automatic cmd(input logic [2:0] op, input int arg, input bit exp_err, input string req);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_arg = AW'(arg);
    @(negedge clk);
    cmd_valid = 0;
    chk(cmd_err == exp_err, req, 192'(cmd_err), 192'(exp_err));
    if (!exp_err) begin
      int d = op[0];
      if (op[2:1] == 0) m_en[d] = arg[0];
      if (op[2:1] == 1) begin
        m_ord[d] = arg + (arg % 2);
        for (int a = 0; a < HL; a++) m_hs[d][a] = '0;
      end
    end
  endtask

  task automatic load(input int d, input int n, input logic [15:0] base);
    cmd(3'(4 + d), 2 * n, 0, "R4 load accept");
    if (n % 2 == 1) m_cf[d][n] = '0;
    for (int i = 0; i < n; i++) begin
      cf_valid = 1; cf_data = base + 16'(i * 3);
      m_cf[d][i] = cf_data;
      @(negedge clk);
    end
    cf_valid = 0;
  endtask

  task automatic frame(input int d, input logic [15:0] base, input string req);
    logic [FRAME*DW-1:0] fin = mk(base);
    logic [FRAME*DW-1:0] ex;
    bit filt = m_en[d] && m_ord[d] != 0;
    int s0 = n_starts, t = 0;
    logic [WL*DW-1:0] ew = exp_win(d, fin);
    if (d == 0) begin tx_in = fin; tx_req = 1; end else begin rx_in = fin; rx_req = 1; end
    do begin @(negedge clk); t++; end while (!(d == 0 ? tx_done : rx_done) && t < 60);
    tx_req = 0; rx_req = 0;
    for (int i = 0; i < FRAME; i++) ex[i*DW +: DW] = fin[i*DW +: DW] + (filt ? 16'h1000 : 16'h0);
    chk(fr_out == ex, req, 192'(fr_out), 192'(ex));
    chk((n_starts - s0) == int'(filt), req, 192'(n_starts - s0), 192'(filt));
    if (filt) begin
      chk(cap_win == ew, {req, " window R6"}, 192'(cap_win), 192'(ew));
      chk(cap_coef == exp_coef(d), {req, " coef R6"}, 192'(cap_coef), 192'(exp_coef(d)));
      chk(int'(cap_ord) == m_ord[d], {req, " order"}, 192'(cap_ord), 192'(m_ord[d]));
      upd_hist(d, fin);
    end
  endtask

  task automatic t_reset;
    chk(cmd_ready == 1 && !tx_done && !rx_done && !eng_start && !cmd_err,
        "R12 reset state", 192'({cmd_ready, tx_done, rx_done, eng_start, cmd_err}), 192'(5'b10000));
  endtask

  task automatic t_bad_cmds;
    cmd(3'd0, 2, 1, "R1 enable argument 2");
    cmd(3'd6, 0, 1, "R1 code 6");
    cmd(3'd3, MAXN + 1, 1, "R2 order above max");
    frame(1, 16'h0300, "R2 rx still bypass after bad order");
  endtask

  task automatic t_bypass;
    frame(0, 16'h0100, "R5 disabled tx passes through");
    cmd(3'd0, 1, 0, "R1 enable tx");
    frame(0, 16'h0110, "R5 order 0 passes through");
  endtask

  task automatic t_filter;
    cmd(3'd2, 4, 0, "R2 tx order 4");
    cmd(3'd4, 6, 1, "R4 byte count mismatch");
    load(0, 4, 16'h7770);
    frame(0, 16'h0200, "R11 first tx frame");
    frame(0, 16'h0210, "R7 second tx frame uses history");
    cmd(3'd2, MAXN + 3, 1, "R2 order 11 rejected");
    frame(0, 16'h0220, "R2 order kept after reject");
  endtask

  task automatic t_odd;
    cmd(3'd2, 3, 0, "R3 odd order 3");
    load(0, 3, 16'h0500);
    frame(0, 16'h0230, "R8 R3 cleared history and pad tap");
    cmd(3'd2, 7, 0, "R3 odd order 7");
    load(0, 7, 16'h0600);
    frame(0, 16'h0240, "R8 order 7 frame");
    frame(0, 16'h0250, "R6 deep history");
  endtask

  task automatic t_rx;
    cmd(3'd3, 2, 0, "R10 rx order 2");
    cmd(3'd1, 1, 0, "R10 rx enable");
    load(1, 2, 16'h0900);
    frame(1, 16'h0400, "R10 rx frame");
    frame(0, 16'h0260, "R10 tx unaffected by rx");
  endtask

  task automatic t_disable;
    cmd(3'd0, 0, 0, "R1 disable tx");
    frame(0, 16'h0270, "R7 bypass keeps history");
    cmd(3'd0, 1, 0, "R1 re-enable tx");
    frame(0, 16'h0280, "R7 history from before bypass");
  endtask

  task automatic t_prio;
    logic [FRAME*DW-1:0] ft = mk(16'h0A00), fr = mk(16'h0B00), ex;
    int t = 0;
    tx_in = ft; rx_in = fr; tx_req = 1; rx_req = 1;
    @(negedge clk);
    chk(cmd_ready == 0, "R12 not ready with frame pending", 192'(cmd_ready), 192'(0));
    do begin @(negedge clk); t++; end while (!tx_done && !rx_done && t < 60);
    chk(tx_done && !rx_done, "R9 tx served first", 192'({tx_done, rx_done}), 192'(2'b10));
    for (int i = 0; i < FRAME; i++) ex[i*DW +: DW] = ft[i*DW +: DW] + 16'h1000;
    chk(fr_out == ex, "R9 tx result", 192'(fr_out), 192'(ex));
    upd_hist(0, ft);
    tx_req = 0; t = 0;
    do begin @(negedge clk); t++; end while (!rx_done && t < 60);
    rx_req = 0;
    for (int i = 0; i < FRAME; i++) ex[i*DW +: DW] = fr[i*DW +: DW] + 16'h1000;
    chk(fr_out == ex && rx_done, "R9 rx follows", 192'(fr_out), 192'(ex));
    upd_hist(1, fr);
    frame(1, 16'h0C00, "R9 rx history after priority");
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin
      m_en[d] = 0; m_ord[d] = 0;
      for (int i = 0; i < MAXN; i++) m_cf[d][i] = '0;
      for (int a = 0; a < HL; a++) m_hs[d][a] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_bad_cmds();
    t_filter();
    t_odd();
    t_rx();
    t_disable();
    t_prio();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog R12 actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule